// File: doc/BRIEF.md
# Prescaled Software Watchdog Timer

This block is a software watchdog for a microcontroller. A 16-bit down-counter starts from a programmed timeout value. It advances on every system clock, or once every 2048 clocks when the prescaler is selected. When the counter reaches zero and then takes one more step, the block raises a one-cycle request: either a system reset request or a non-maskable interrupt request, as the configuration chooses. The counter then reloads from the timeout value.

Software keeps the system alive by writing two keys in order to the service register. Each correct pair reloads the counter and restarts the prescaler. The configuration (enable, prescale select, action select and timeout) can be written only once after reset. The freeze-stop control can be rewritten at any time. Counting pauses, and both the count and the prescale phase are kept, while the processor is in a low-power mode. It also pauses during debug freeze when freeze-stop is set. The present count is visible on a status output.

Top module: `swdog_top`

## Requirements
- R1: A service write (wr_sel=1) of key 0x556C in wr_data[15:0], followed by a service write of key 0xAA39, loads the count with the timeout value on the edge of the second write and restarts the prescale phase. Writing 0x556C again while armed keeps the sequence armed.
- R2: A service write of 0xAA39 that is not directly preceded by a 0x556C service write leaves the count untouched. So does any service value other than the two keys, and it also disarms the sequence.
- R3: With the prescaler off, the count decrements by one on every enabled, unheld clock. With the prescaler on, it decrements once every 2048 such clocks.
- R4: A step taken while the count is 0 pulses rst_req_o (action bit 0) or nmi_req_o (action bit 1) for one cycle, never both, and reloads the timeout value. In either mode the request does not come again until timeout+1 further steps have elapsed.
- R5: With the enable bit cleared, the count and the prescale phase hold and no request is raised. Service writes still reload the count.
- R6: While freeze is high and freeze-stop is 1, the count and the prescale phase hold. With freeze-stop at 0, freeze has no effect.
- R7: While lowpower is high, the count and the prescale phase hold. Counting resumes from the kept values when lowpower falls.
- R8: A configuration write (wr_sel=0) uses these fields: bit 0 enable, bit 1 prescale select, bit 2 action select (1 = NMI), bit 3 freeze-stop, bits 31:16 timeout. Only the first configuration write after reset changes enable, prescale, action and timeout. Freeze-stop follows every configuration write.
- R9: After reset the count is 0xFFFF, the block is enabled with the prescaler on, the action is reset, freeze-stop is 1, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 service |
| wr_data | input | 32 | Write data |
| freeze | input | 1 | Debug freeze indication |
| lowpower | input | 1 | Processor is in doze, sleep or deep sleep |
| count_o | output | 16 | Present counter value |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
Directed sequences first run the default prescaled countdown from reset. They then run direct-clock countdowns to a timeout in both action modes, which shows whether the right request fires and whether it fires only once per period. Out-of-order and foreign service keys are set against correct key pairs to separate a true reload from ordinary counting. Freeze with each freeze-stop setting, low-power holds in the middle of a prescale period, and a second configuration write show which inputs hold the counter and which settings are locked. A seeded random mix of keys, ignored configuration writes and hold inputs is compared every cycle against a bench model.

// File: rtl/swdog_pkg.sv
package swdog_pkg;

    localparam int          DEF_CNT_W   = 16;
    localparam int          DEF_DIV     = 2048;
    localparam logic [15:0] DEF_KEY_ARM = 16'h556C;
    localparam logic [15:0] DEF_KEY_GO  = 16'hAA39;

    // configuration word field positions
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_PRE_BIT = 1;
    localparam int CFG_ACT_BIT = 2;
    localparam int CFG_FRZ_BIT = 3;
    localparam int CFG_TMO_LSB = 16;

    typedef enum logic {
        ACT_RESET = 1'b0,
        ACT_NMI   = 1'b1
    } action_e;

    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic    enable;
        logic    prescale;
        action_e action;
    } mode_t;

    localparam mode_t MODE_AT_RESET = '{enable: 1'b1, prescale: 1'b1, action: ACT_RESET};

    function automatic logic key_match(input logic [15:0] value, input logic [15:0] key);
        return value == key;
    endfunction

endpackage

// File: rtl/swdog_regs.sv
module swdog_regs
    import swdog_pkg::*;
#(
    parameter int          CNT_W    = DEF_CNT_W,
    parameter logic [CNT_W-1:0] INIT_TMO = '1,
    localparam int         DATA_W   = CFG_TMO_LSB + CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_data,
    output mode_t             mode_o,
    output logic [CNT_W-1:0]  timeout_o,
    output logic              frz_stop_o
);

    logic locked_q;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_data[CFG_TMO_LSB-1:CFG_FRZ_BIT+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o     <= MODE_AT_RESET;
            timeout_o  <= INIT_TMO;
            frz_stop_o <= 1'b1;
            locked_q   <= 1'b0;
        end else if (cfg_we) begin
            frz_stop_o <= cfg_data[CFG_FRZ_BIT];
            if (!locked_q) begin
                mode_o.enable   <= cfg_data[CFG_EN_BIT];
                mode_o.prescale <= cfg_data[CFG_PRE_BIT];
                mode_o.action   <= action_e'(cfg_data[CFG_ACT_BIT]);
                timeout_o       <= cfg_data[DATA_W-1:CFG_TMO_LSB];
                locked_q        <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/swdog_service.sv
module swdog_service
    import swdog_pkg::*;
#(
    parameter logic [15:0] KEY_ARM = DEF_KEY_ARM,
    parameter logic [15:0] KEY_GO  = DEF_KEY_GO
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        svc_we,
    input  logic [15:0] svc_key,
    output logic        reload_o
);

    svc_state_e state_q;

    assign reload_o = svc_we && (state_q == SVC_ARMED) && key_match(svc_key, KEY_GO);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SVC_IDLE;
        end else if (svc_we) begin
            state_q <= key_match(svc_key, KEY_ARM) ? SVC_ARMED : SVC_IDLE;
        end
    end

endmodule

// File: rtl/swdog_prescaler.sv
module swdog_prescaler #(
    parameter int DIV = 2048,
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic tick_o
);

    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick_o = adv && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (adv) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/swdog_counter.sv
module swdog_counter
    import swdog_pkg::*;
#(
    parameter int               CNT_W    = DEF_CNT_W,
    parameter logic [CNT_W-1:0] INIT_TMO = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             step,
    input  logic [CNT_W-1:0] timeout,
    input  action_e          action,
    output logic [CNT_W-1:0] count_o,
    output logic             rst_req_o,
    output logic             nmi_req_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o   <= INIT_TMO;
            rst_req_o <= 1'b0;
            nmi_req_o <= 1'b0;
        end else begin
            rst_req_o <= 1'b0;
            nmi_req_o <= 1'b0;
            if (reload) begin
                count_o <= timeout;
            end else if (step) begin
                if (count_o == '0) begin
                    count_o <= timeout;
                    if (action == ACT_NMI) nmi_req_o <= 1'b1;
                    else                   rst_req_o <= 1'b1;
                end else begin
                    count_o <= count_o - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/swdog_top.sv
module swdog_top
    import swdog_pkg::*;
#(
    parameter int               CNT_W    = DEF_CNT_W,
    parameter int               DIV      = DEF_DIV,
    parameter logic [15:0]      KEY_ARM  = DEF_KEY_ARM,
    parameter logic [15:0]      KEY_GO   = DEF_KEY_GO,
    parameter logic [CNT_W-1:0] INIT_TMO = '1,
    localparam int              DATA_W   = CFG_TMO_LSB + CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              freeze,
    input  logic              lowpower,
    output logic [CNT_W-1:0]  count_o,
    output logic              rst_req_o,
    output logic              nmi_req_o
);

    mode_t            mode_q;
    logic [CNT_W-1:0] timeout;
    logic             frz_stop;
    logic             svc_reload;
    logic             hold;
    logic             run;
    logic             pre_tick;
    logic             cnt_step;

    assign hold     = lowpower || (freeze && frz_stop);
    assign run      = mode_q.enable && !hold;
    assign cnt_step = run && (mode_q.prescale ? pre_tick : 1'b1);

    swdog_regs #(.CNT_W(CNT_W), .INIT_TMO(INIT_TMO)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (wr_en && !wr_sel),
        .cfg_data   (wr_data),
        .mode_o     (mode_q),
        .timeout_o  (timeout),
        .frz_stop_o (frz_stop)
    );

    swdog_service #(.KEY_ARM(KEY_ARM), .KEY_GO(KEY_GO)) u_svc (
        .clk      (clk),
        .rst      (rst),
        .svc_we   (wr_en && wr_sel),
        .svc_key  (wr_data[15:0]),
        .reload_o (svc_reload)
    );

    swdog_prescaler #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (svc_reload),
        .adv    (run && mode_q.prescale),
        .tick_o (pre_tick)
    );

    swdog_counter #(.CNT_W(CNT_W), .INIT_TMO(INIT_TMO)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .reload    (svc_reload),
        .step      (cnt_step),
        .timeout   (timeout),
        .action    (mode_q.action),
        .count_o   (count_o),
        .rst_req_o (rst_req_o),
        .nmi_req_o (nmi_req_o)
    );

endmodule

// File: rtl/swdog_checker.sv
module swdog_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             freeze,
    input logic             lowpower,
    input logic             frz_stop,
    input logic             enable,
    input logic             svc_reload,
    input logic [CNT_W-1:0] timeout,
    input logic [CNT_W-1:0] count_o,
    input logic             rst_req_o,
    input logic             nmi_req_o
);

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        !(rst_req_o && nmi_req_o)); // R4

    AST_PULSE_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (rst_req_o || nmi_req_o) |-> (count_o == $past(timeout))); // R4

    AST_SERVICE_LOADS: assert property (@(posedge clk) disable iff (rst)
        svc_reload |=> (count_o == $past(timeout))); // R1

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !(rst_req_o || nmi_req_o)); // R5

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (freeze && frz_stop && !svc_reload) |=> $stable(count_o)); // R6

    AST_LOWPOWER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (lowpower && !svc_reload) |=> $stable(count_o)); // R7

    AST_STEP_OR_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(svc_reload) && (count_o != $past(count_o)))
        |-> ((count_o == $past(count_o) - 1'b1) || (count_o == $past(timeout)))); // R3

endmodule

bind swdog_top swdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .freeze     (freeze),
    .lowpower   (lowpower),
    .frz_stop   (frz_stop),
    .enable     (mode_q.enable),
    .svc_reload (svc_reload),
    .timeout    (timeout),
    .count_o    (count_o),
    .rst_req_o  (rst_req_o),
    .nmi_req_o  (nmi_req_o)
);

// File: tb/tb_swdog_top.sv
module tb_swdog_top;

    localparam logic [15:0] KA = 16'h556C;
    localparam logic [15:0] KB = 16'hAA39;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        freeze = 1'b0;
    logic        lowpower = 1'b0;
    logic [15:0] count_o;
    logic        rst_req_o;
    logic        nmi_req_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    // bench model state
    logic [15:0] m_cnt, m_tmo;
    int          m_div;
    bit          m_armed, m_en, m_pre, m_nmi, m_fstop, m_lock, m_rreq, m_nreq;

    swdog_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .freeze(freeze), .lowpower(lowpower), .count_o(count_o),
        .rst_req_o(rst_req_o), .nmi_req_o(nmi_req_o)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input logic [15:0] tmo, input bit fs, input bit nmi,
                                       input bit pre, input bit en);
        return {tmo, 12'h000, fs, nmi, pre, en};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_init();
        m_cnt = 16'hFFFF; m_tmo = 16'hFFFF; m_div = 0; m_armed = 0;
        m_en = 1; m_pre = 1; m_nmi = 0; m_fstop = 1; m_lock = 0; m_rreq = 0; m_nreq = 0;
    endtask

    task automatic model_edge(input bit we, input bit sel, input logic [31:0] d,
                              input bit frz, input bit lp);
        bit hold, run, tick, reload;
        m_rreq = 0; m_nreq = 0;
        hold   = lp || (frz && m_fstop);
        run    = m_en && !hold;
        reload = we && sel && m_armed && (d[15:0] == KB);
        if (we && sel) m_armed = (d[15:0] == KA);
        if (reload) begin
            m_cnt = m_tmo; m_div = 0;
        end else if (run) begin
            tick = 1;
            if (m_pre) begin
                tick  = (m_div == 2047);
                m_div = tick ? 0 : m_div + 1;
            end
            if (tick) begin
                if (m_cnt == 0) begin
                    m_cnt = m_tmo;
                    if (m_nmi) m_nreq = 1; else m_rreq = 1;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end
        if (we && !sel) begin
            m_fstop = d[3];
            if (!m_lock) begin
                m_en = d[0]; m_pre = d[1]; m_nmi = d[2]; m_tmo = d[31:16]; m_lock = 1;
            end
        end
    endtask

    task automatic step(input bit we, input bit sel, input logic [31:0] d,
                        input bit frz, input bit lp);
        wr_en = we; wr_sel = sel; wr_data = d; freeze = frz; lowpower = lp;
        @(posedge clk);
        model_edge(we, sel, d, frz, lp);
        @(negedge clk);
        chk(count_o == m_cnt, "R3", "count vs model", count_o, m_cnt);
        chk(rst_req_o == m_rreq, "R4", "rst_req vs model", rst_req_o, m_rreq);
        chk(nmi_req_o == m_nreq, "R4", "nmi_req vs model", nmi_req_o, m_nreq);
    endtask

    task automatic idle(input int n, input bit frz = 0, input bit lp = 0);
        for (int i = 0; i < n; i++) step(0, 0, '0, frz, lp);
    endtask

    task automatic cfg(input logic [31:0] d);
        step(1, 0, d, 0, 0);
    endtask

    task automatic svc(input logic [15:0] k);
        step(1, 1, {16'h0000, k}, 0, 0);
    endtask

    task automatic service();
        svc(KA);
        svc(KB);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wr_en = 0; wr_sel = 0; wr_data = '0; freeze = 0; lowpower = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_init();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        end
    endtask

    initial begin
        #(8 * 190000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'h00C0FFEE));

        // R9: reset state, then R3 default prescaled counting
        do_reset();
        chk(count_o == 16'hFFFF, "R9", "count after reset", count_o, 16'hFFFF);
        chk(!rst_req_o && !nmi_req_o, "R9", "no request after reset", {rst_req_o, nmi_req_o}, 0);
        idle(2047);
        chk(count_o == 16'hFFFF, "R3", "prescaled count before 2048 clocks", count_o, 16'hFFFF);
        idle(1);
        chk(count_o == 16'hFFFE, "R3", "prescaled step after 2048 clocks", count_o, 16'hFFFE);

        // direct clock, reset action, timeout 5
        do_reset();
        cfg(mk(16'd5, 1, 0, 0, 1));
        service();
        chk(count_o == 16'd5, "R1", "service loads timeout", count_o, 5);
        idle(5);
        chk(count_o == 16'd0 && !rst_req_o, "R3", "count reaches zero", count_o, 0);
        idle(1);
        chk(rst_req_o && !nmi_req_o, "R4", "reset request on expiry", {rst_req_o, nmi_req_o}, 2'b10);
        chk(count_o == 16'd5, "R4", "reload after expiry", count_o, 5);
        idle(1);
        chk(!rst_req_o, "R4", "request lasts one cycle", rst_req_o, 0);

        // R8: second configuration write ignored except freeze-stop
        cfg(mk(16'd9, 0, 1, 1, 0));
        service();
        chk(count_o == 16'd5, "R8", "timeout unchanged by second write", count_o, 5);
        idle(6);
        chk(rst_req_o && !nmi_req_o, "R8", "action/enable/prescale unchanged", {rst_req_o, nmi_req_o}, 2'b10);

        // R6: freeze-stop now 0 -> freeze ignored
        service();
        idle(3, 1, 0);
        chk(count_o == 16'd2, "R6", "freeze ignored with freeze-stop 0", count_o, 2);
        cfg(mk(16'd0, 1, 0, 0, 0));
        idle(3, 1, 0);
        chk(count_o == 16'd1, "R6", "freeze holds with freeze-stop 1", count_o, 1);
        idle(4, 0, 1);
        chk(count_o == 16'd1, "R7", "low power holds count", count_o, 1);
        idle(1);
        chk(count_o == 16'd0, "R7", "count resumes after low power", count_o, 0);

        // R2 / R1 key ordering, NMI action, timeout 100
        do_reset();
        cfg(mk(16'd100, 1, 1, 0, 1));
        service();
        svc(KB);
        chk(count_o == 16'd99, "R2", "lone second key ignored", count_o, 99);
        svc(KA); svc(16'h1234); svc(KB);
        chk(count_o == 16'd96, "R2", "foreign key disarms", count_o, 96);
        svc(KA); svc(KA); svc(KB);
        chk(count_o == 16'd100, "R1", "repeated first key stays armed", count_o, 100);
        idle(100);
        idle(1);
        chk(nmi_req_o && !rst_req_o, "R4", "nmi request on expiry", {rst_req_o, nmi_req_o}, 2'b01);
        idle(100);
        chk(!nmi_req_o && count_o == 16'd0, "R4", "no nmi refire within period", count_o, 0);
        idle(1);
        chk(nmi_req_o, "R4", "nmi after full period", nmi_req_o, 1);

        // R5: disabled
        do_reset();
        cfg(mk(16'd3, 1, 0, 0, 0));
        idle(50);
        chk(count_o == 16'hFFFF, "R5", "disabled count holds", count_o, 16'hFFFF);
        service();
        idle(20);
        chk(count_o == 16'd3 && !rst_req_o && !nmi_req_o, "R5", "disabled no request", count_o, 3);

        // R7 prescale phase held across freeze and low power
        do_reset();
        cfg(mk(16'd1, 1, 0, 1, 1));
        service();
        idle(1000);
        idle(500, 1, 0);
        idle(300, 0, 1);
        idle(1047);
        chk(count_o == 16'd1, "R7", "prescale phase kept (before)", count_o, 1);
        idle(1);
        chk(count_o == 16'd0, "R7", "prescale phase kept (step)", count_o, 0);
        idle(2048);
        chk(rst_req_o, "R4", "prescaled expiry", rst_req_o, 1);

        // random mix against the model
        do_reset();
        cfg(mk(16'($urandom % 40), 1'($urandom), 1'($urandom), 0, 1));
        for (int i = 0; i < 4000; i++) begin
            r = $urandom % 16;
            case (r)
                0: svc(KA);
                1: svc(KB);
                2: svc(16'($urandom));
                3: cfg($urandom);
                default: idle(1, ($urandom % 4) == 0, ($urandom % 8) == 0);
            endcase
        end

        summary();
        $finish;
    end

endmodule